// File: doc/BRIEF.md
# Set/Clear GPIO Register Bank

A memory-mapped general-purpose I/O controller for 32 pins, arranged as two identical 16-pin banks. The upper bank sits at a fixed byte offset above the lower one and reuses the same register layout. Within a bank, each pin index is the global pin number modulo 16. Every writable register takes a 32-bit word in set/clear form: the low half names pins whose bit is to be set and the high half names pins whose bit is to be cleared. Software can therefore change one pin without reading the register first, and a write never disturbs pins it does not name.

Each bank holds eight per-pin registers: output value, input enable, output enable, open-drain enable, pull-up enable, pull-down enable, input invert and output invert. It also has a read-only input value register. The pad side of the block drives logical data, output-enable and separate pull-up and pull-down controls for every pin. It takes in the raw pin levels through a two-flop synchronizer. Access is through a simple synchronous register bus with single-cycle write strobes and registered read data.

Top module: `gpio_setclr_bank`

## Requirements
- R1: A write to a writable register sets bit n of the bank register when data bit n (n = 0..15) is 1 and clears it when data bit n+16 is 1. Bits with both data bits 0 keep their value.
- R2: When a write has both the set bit and the clear bit of a pin at 1, that pin's bit ends up 0.
- R3: Byte address bit 7 selects the bank (0 = pins 0..15, 1 = pins 16..31, offset 0x80), and bank bit k is pin 16*bank+k. A write to one bank leaves every register and pad output of the other bank unchanged.
- R4: The word index is bus_addr[5:2]: 0 output value, 1 input enable, 2 output enable, 3 open-drain, 4 pull-up, 5 pull-down, 6 input invert, 7 output invert, 8 input value (read-only). Writes to index 8, to indices 9..15, to addresses with bus_addr[6]=1, or to addresses with bus_addr[1:0]≠0 change nothing. Reads of those unmapped addresses return 0.
- R5: bus_rdata is updated on the clock edge where bus_rd is 1 and holds its value otherwise. Bits [15:0] carry the addressed bank register (pin k in bit k) and bits [31:16] read 0.
- R6: With open-drain off, pad_out of a pin equals output value XOR output invert, and pad_oe equals its output enable.
- R7: With open-drain on, pad_out is 0, and pad_oe is 1 only when output enable is 1 and output value XOR output invert is 0.
- R8: The input value register bit of a pin equals its synchronized pin level XOR input invert, ANDed with input enable. A pin change becomes readable through a read strobe issued on the third rising edge after the change.
- R9: pad_pd equals the pull-down enable. pad_pu equals pull-up enable AND NOT pull-down enable.
- R10: After reset every register is 0, so every pad output is 0, pads do not drive, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data registered on the same edge |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Set/clear write word |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pad_out | output | 32 | Pad drive value |
| pad_oe | output | 32 | Pad output enable |
| pad_pu | output | 32 | Pull-up enable |
| pad_pd | output | 32 | Pull-down enable |

## Verification
Register writes take effect on the edge that samples bus_wr. The pad outputs follow combinationally, so the bench compares pad_out, pad_oe, pad_pu and pad_pd against its model one half-cycle after that edge. A read strobe is captured on one edge and bus_rdata is compared half a cycle later. After a change on pin_in, the bench lets two rising edges pass for the synchronizer, then issues the read whose strobe lands on the third edge. Stimulus is always driven on falling edges, so no comparison races a register update.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

   typedef enum logic [3:0] {
      REG_OUTV = 4'd0,
      REG_IEN  = 4'd1,
      REG_OEN  = 4'd2,
      REG_ODE  = 4'd3,
      REG_PUE  = 4'd4,
      REG_PDE  = 4'd5,
      REG_IINV = 4'd6,
      REG_OINV = 4'd7,
      REG_INV  = 4'd8
   } reg_idx_e;

   localparam int NATTR  = 8;
   localparam int IDX_LSB = 2;
   localparam int IDX_W   = 4;

endpackage

// File: rtl/gpio_sc_reg.sv
module gpio_sc_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  logic [W-1:0] set_bits,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] q
);
   // clear applied after set so a doubly named pin ends at 0
   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (we)
         q <= (q | set_bits) & ~clr_bits;
   end
endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain[0] <= '0;
            else     chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_sc_pad.sv
module gpio_sc_pad #(
   parameter int W = 16
) (
   input  logic [W-1:0] outv,
   input  logic [W-1:0] oinv,
   input  logic [W-1:0] oen,
   input  logic [W-1:0] ode,
   input  logic [W-1:0] pue,
   input  logic [W-1:0] pde,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] pad_pu,
   output logic [W-1:0] pad_pd
);
   for (genvar p = 0; p < W; p++) begin : g_pin
      logic level;
      assign level = outv[p] ^ oinv[p];
      always_comb begin
         if (ode[p]) begin
            pad_out[p] = 1'b0;
            pad_oe[p]  = oen[p] & ~level;
         end else begin
            pad_out[p] = level;
            pad_oe[p]  = oen[p];
         end
         pad_pd[p] = pde[p];
         pad_pu[p] = pue[p] & ~pde[p];
      end
   end
endmodule

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank
   import gpio_sc_pkg::*;
#(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [W-1:0]     wset,
   input  logic [W-1:0]     wclr,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [W-1:0]     rd_word,
   input  logic [W-1:0]     pin_in,
   output logic [W-1:0]     pad_out,
   output logic [W-1:0]     pad_oe,
   output logic [W-1:0]     pad_pu,
   output logic [W-1:0]     pad_pd,
   output logic [W-1:0]     ode_q
);
   logic [W-1:0] attr_q [NATTR];
   logic [W-1:0] pin_sync;
   logic [W-1:0] in_val;

   for (genvar a = 0; a < NATTR; a++) begin : g_attr
      gpio_sc_reg #(.W(W)) u_reg (
         .clk      (clk),
         .rst      (rst),
         .we       (wr_en && (wr_idx == IDX_W'(a))),
         .set_bits (wset),
         .clr_bits (wclr),
         .q        (attr_q[a])
      );
   end

   gpio_sc_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin_in),
      .q   (pin_sync)
   );

   assign in_val = (pin_sync ^ attr_q[REG_IINV]) & attr_q[REG_IEN];

   always_comb begin
      if (rd_idx < IDX_W'(NATTR))
         rd_word = attr_q[rd_idx[2:0]];
      else if (rd_idx == REG_INV)
         rd_word = in_val;
      else
         rd_word = '0;
   end

   gpio_sc_pad #(.W(W)) u_pad (
      .outv    (attr_q[REG_OUTV]),
      .oinv    (attr_q[REG_OINV]),
      .oen     (attr_q[REG_OEN]),
      .ode     (attr_q[REG_ODE]),
      .pue     (attr_q[REG_PUE]),
      .pde     (attr_q[REG_PDE]),
      .pad_out (pad_out),
      .pad_oe  (pad_oe),
      .pad_pu  (pad_pu),
      .pad_pd  (pad_pd)
   );

   assign ode_q = attr_q[REG_ODE];
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
   import gpio_sc_pkg::*;
#(
   parameter int BANK_W      = 16,
   parameter int NBANKS      = 2,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int BANK_OFS    = 128,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic [BANK_W*NBANKS-1:0] pin_in,
   output logic [BANK_W*NBANKS-1:0] pad_out,
   output logic [BANK_W*NBANKS-1:0] pad_oe,
   output logic [BANK_W*NBANKS-1:0] pad_pu,
   output logic [BANK_W*NBANKS-1:0] pad_pd
);
   localparam int NPINS    = BANK_W * NBANKS;
   localparam int BANK_BIT = $clog2(BANK_OFS);
   localparam int SEL_W    = $clog2(NBANKS);
   localparam int IDX_TOP  = IDX_LSB + IDX_W;
   localparam int HI_LSB   = BANK_BIT + SEL_W;

   // elaboration checks on the parameter set
   if (DATA_W != 2 * BANK_W) begin : g_bad_data
      $error("DATA_W must be twice BANK_W");
   end
   if (NBANKS < 2 || (1 << SEL_W) != NBANKS) begin : g_bad_banks
      $error("NBANKS must be a power of two, at least 2");
   end
   if ((1 << BANK_BIT) != BANK_OFS || BANK_BIT < IDX_TOP) begin : g_bad_ofs
      $error("BANK_OFS must be a power of two covering the register window");
   end
   if (HI_LSB > ADDR_W) begin : g_bad_addr
      $error("ADDR_W too narrow for bank select");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SEL_W-1:0]  sel;
   logic [IDX_W-1:0]  idx;
   logic              gap_zero;
   logic              hi_zero;
   logic              mapped;
   logic [BANK_W-1:0] bank_rd [NBANKS];
   logic [NPINS-1:0]  ode_all;

   assign sel = bus_addr[BANK_BIT +: SEL_W];
   assign idx = bus_addr[IDX_LSB +: IDX_W];

   if (BANK_BIT > IDX_TOP) begin : g_gap
      assign gap_zero = (bus_addr[BANK_BIT-1:IDX_TOP] == '0);
   end else begin : g_nogap
      assign gap_zero = 1'b1;
   end

   if (ADDR_W > HI_LSB) begin : g_hi
      assign hi_zero = (bus_addr[ADDR_W-1:HI_LSB] == '0);
   end else begin : g_nohi
      assign hi_zero = 1'b1;
   end

   assign mapped = gap_zero && hi_zero && (bus_addr[IDX_LSB-1:0] == '0);

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      gpio_sc_bank #(.W(BANK_W), .SYNC_STAGES(SYNC_STAGES)) u_bank (
         .clk     (clk),
         .rst     (rst),
         .wr_en   (bus_wr && mapped && (sel == SEL_W'(b))),
         .wr_idx  (idx),
         .wset    (bus_wdata[BANK_W-1:0]),
         .wclr    (bus_wdata[DATA_W-1:BANK_W]),
         .rd_idx  (idx),
         .rd_word (bank_rd[b]),
         .pin_in  (pin_in[b*BANK_W +: BANK_W]),
         .pad_out (pad_out[b*BANK_W +: BANK_W]),
         .pad_oe  (pad_oe[b*BANK_W +: BANK_W]),
         .pad_pu  (pad_pu[b*BANK_W +: BANK_W]),
         .pad_pd  (pad_pd[b*BANK_W +: BANK_W]),
         .ode_q   (ode_all[b*BANK_W +: BANK_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst)
         bus_rdata <= '0;
      else if (bus_rd)
         bus_rdata <= mapped ? {{(DATA_W-BANK_W){1'b0}}, bank_rd[sel]} : '0;
   end
endmodule

// File: rtl/gpio_sc_checks.sv
module gpio_sc_checks
   import gpio_sc_pkg::*;
#(
   parameter int BANK_W   = 16,
   parameter int NBANKS   = 2,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int BANK_OFS = 128
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     bus_wr,
   input logic                     bus_rd,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic [DATA_W-1:0]        bus_wdata,
   input logic [DATA_W-1:0]        bus_rdata,
   input logic [BANK_W*NBANKS-1:0] pad_out,
   input logic [BANK_W*NBANKS-1:0] pad_oe,
   input logic [BANK_W*NBANKS-1:0] pad_pu,
   input logic [BANK_W*NBANKS-1:0] pad_pd,
   input logic [BANK_W*NBANKS-1:0] ode_all
);
   localparam int BANK_BIT = $clog2(BANK_OFS);
   localparam logic [ADDR_W-1:0] OEN_B0 = ADDR_W'(4 * int'(REG_OEN));

   AST_CLEAR_WINS_OE: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == OEN_B0) |=>
      ((pad_oe[BANK_W-1:0] & $past(bus_wdata[DATA_W-1:BANK_W])) == '0)); // R2

   AST_BANK_ISOLATE: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && !bus_addr[BANK_BIT]) |=>
      ($stable(pad_oe[2*BANK_W-1:BANK_W]) && $stable(pad_out[2*BANK_W-1:BANK_W]) &&
       $stable(pad_pu[2*BANK_W-1:BANK_W]) && $stable(pad_pd[2*BANK_W-1:BANK_W]))); // R3

   AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
      !bus_rd |=> $stable(bus_rdata)); // R5

   AST_OD_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
      ((ode_all & pad_out) == '0)); // R7

   AST_PULL_EXCL: assert property (@(posedge clk) disable iff (rst)
      ((pad_pu & pad_pd) == '0)); // R9

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pad_oe == '0 && pad_out == '0 && pad_pu == '0 &&
                      pad_pd == '0 && bus_rdata == '0)); // R10
endmodule

bind gpio_setclr_bank gpio_sc_checks #(
   .BANK_W(BANK_W), .NBANKS(NBANKS), .ADDR_W(ADDR_W),
   .DATA_W(DATA_W), .BANK_OFS(BANK_OFS)
) u_checks (
   .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
   .ode_all(ode_all)
);

// File: tb/gpio_setclr_bank_test.sv
`timescale 1ns/1ps
module gpio_setclr_bank_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pad_out, pad_oe, pad_pu, pad_pd;

   int errors = 0;
   int checks = 0;
   logic [15:0] m [2][8];

   always #10 clk = ~clk;

   gpio_setclr_bank uut (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_pu(pad_pu), .pad_pd(pad_pd)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit is_mapped(input logic [7:0] a);
      return (a[1:0] == 2'b00) && !a[6];
   endfunction

   function automatic logic [15:0] exp_in(input int b);
      return (pin_in[b*16 +: 16] ^ m[b][6]) & m[b][1];
   endfunction

   function automatic logic [31:0] exp_reg(input logic [7:0] a);
      int b = int'(a[7]);
      int i = int'(a[5:2]);
      if (!is_mapped(a)) return '0;
      if (i < 8) return {16'h0, m[b][i]};
      if (i == 8) return {16'h0, exp_in(b)};
      return '0;
   endfunction

   // all tasks are entered on a falling edge and return on one
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      if (is_mapped(a) && a[5:2] < 4'd8)
         m[int'(a[7])][int'(a[5:2])] = (m[int'(a[7])][int'(a[5:2])] | d[15:0]) & ~d[31:16];
   endtask

   task automatic rd_check(input logic [7:0] a, input string tag);
      logic [31:0] e;
      bus_rd = 1'b1; bus_addr = a;
      e = exp_reg(a);
      @(negedge clk);
      bus_rd = 1'b0;
      chk(bus_rdata === e, tag, bus_rdata, e);
   endtask

   task automatic pads_check(input string tag);
      logic [31:0] eo, eoe, epu, epd;
      for (int b = 0; b < 2; b++) begin
         logic [15:0] lv, od;
         lv = m[b][0] ^ m[b][7];
         od = m[b][3];
         eo[b*16 +: 16]  = lv & ~od;
         eoe[b*16 +: 16] = m[b][2] & ~(od & lv);
         epd[b*16 +: 16] = m[b][5];
         epu[b*16 +: 16] = m[b][4] & ~m[b][5];
      end
      chk(pad_out === eo,  {tag, " pad_out"}, pad_out, eo);
      chk(pad_oe === eoe,  {tag, " pad_oe"},  pad_oe,  eoe);
      chk(pad_pu === epu,  {tag, " pad_pu"},  pad_pu,  epu);
      chk(pad_pd === epd,  {tag, " pad_pd"},  pad_pd,  epd);
   endtask

   task automatic set_pins(input logic [31:0] v);
      pin_in = v;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(20ns * 100000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < 8; i++) m[b][i] = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R10 reset state
      pads_check("R10 reset");
      for (int i = 0; i < 9; i++) rd_check(8'(i * 4), "R10 reset read");

      // R1 set then partial clear of output value
      wr(8'h00, 32'h0000_00F5);
      rd_check(8'h00, "R1 set");
      wr(8'h00, 32'h0005_0000);
      rd_check(8'h00, "R1 clear");
      wr(8'h00, 32'h0000_0000);
      rd_check(8'h00, "R1 zero word unchanged");

      // R2 clear wins on output enable
      wr(8'h08, 32'h0003_0003);
      rd_check(8'h08, "R2 both bits");
      wr(8'h08, 32'h0000_FFFF);
      wr(8'h08, 32'h8000_8000);
      rd_check(8'h08, "R2 clear wins");

      // R6 push-pull with inversion
      wr(8'h1C, 32'h0000_00F0);
      pads_check("R6 push-pull");

      // R7 open-drain
      wr(8'h0C, 32'h0000_0F0F);
      pads_check("R7 open-drain");

      // R9 pull priority
      wr(8'h10, 32'h0000_00FF);
      wr(8'h14, 32'h0000_0F00);
      pads_check("R9 pulls");

      // R3 high bank at offset 0x80 isolated from low bank
      wr(8'h88, 32'h0000_A5A5);
      wr(8'h80, 32'h0000_FFFF);
      pads_check("R3 high bank");
      rd_check(8'h08, "R3 low bank unchanged");
      rd_check(8'h88, "R3 high bank read");

      // R4 ignored writes
      wr(8'h20, 32'h0000_FFFF);
      wr(8'h48, 32'h0000_FFFF);
      wr(8'h09, 32'hFFFF_0000);
      wr(8'h24, 32'h0000_FFFF);
      pads_check("R4 ignored writes");
      rd_check(8'h08, "R4 unaligned ignored");
      rd_check(8'h48, "R4 unmapped read");
      rd_check(8'h24, "R4 unused index read");

      // R5 rdata holds without strobe
      rd_check(8'h88, "R5 read");
      bus_addr = 8'h00;
      @(negedge clk);
      chk(bus_rdata === exp_reg(8'h88), "R5 hold", bus_rdata, exp_reg(8'h88));

      // R8 input path
      wr(8'h04, 32'h0000_FF00);
      wr(8'h84, 32'h0000_FFFF);
      wr(8'h98, 32'h0000_0F0F);
      set_pins(32'h1234_ABCD);
      rd_check(8'h20, "R8 input low");
      rd_check(8'hA0, "R8 input high");

      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [7:0] a;
         a = {1'($urandom_range(0, 1)), 1'b0, 4'($urandom_range(0, 9)), 2'b00};
         if ($urandom_range(0, 15) == 0) a = 8'($urandom);
         if ($urandom_range(0, 7) == 0) begin
            set_pins($urandom);
            rd_check({a[7], 7'h20}, "R8 random input");
         end
         wr(a, $urandom);
         pads_check("R1 random pads");
         rd_check(a, "R4 random read");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule